// File: doc/BRIEF.md
# External Bus Access Width Splitter

This block sits between an internal requester and an external memory port. The internal side issues 32-bit-style accesses. The external port's data width is chosen per access as 8, 16 or 32 bits. For each accepted request the block plans the sequence of external bus cycles it needs and issues them one at a time. It waits for a cycle-done input before it moves on. For every cycle it generates the address and steers the bytes between the request's data word and the external lanes, according to the byte order that was captured at power-on reset.

Requests are single byte, half-word (2 bytes), longword (4 bytes), or 8-, 16- and 32-byte blocks. Blocks are handled as a run of longwords. A 32-byte block starts at the requested longword and wraps inside its aligned 32-byte window. The bus stays owned for the whole transfer. When the last cycle completes, the block returns one response that carries the assembled read data. A request that is misaligned or otherwise invalid is answered with an error response and causes no external activity.

Top module: `bus_width_splitter`

## Requirements
- R1: The byte order is taken from `endian_sel` on every clock edge while `rst_n` is low: low selects big endian, high selects little endian. After `rst_n` rises, changes on `endian_sel` have no effect until the next reset.
- R2: Value layout: in big endian the most significant byte of a value lives at its lowest address, and in little endian the least significant byte does. On the external port, the byte at offset o inside a port word of W bytes uses lane W-1-o in big endian and lane o in little endian. Lane n is `ext_wdata`/`ext_rdata` bits 8n+7..8n.
- R3: `req_size` codes are 0 = byte, 1 = half-word, 2 = longword, 3 = 8-byte, 4 = 16-byte and 5 = 32-byte. `req_port_w` codes are 0 = 8-bit, 1 = 16-bit and 2 = 32-bit. With `req_narrow_only` high, only codes 0 and 1 are legal.
- R4: A request of T bytes is issued as T/S external cycles, where S is the smaller of the port width and the element size (the request size, capped at 4 bytes). Each cycle's address is S bytes above the previous one.
- R5: A longword on an 8-bit port takes exactly four cycles, at addresses A, A+1, A+2 and A+3.
- R6: 8-byte and 16-byte blocks carry 2 and 4 longwords. Longword j sits at address base+4j and at bits 32j+31..32j of `req_wdata`/`resp_rdata`. Each longword follows the byte order of R2. Values of 4 bytes or less sit in the low bits.
- R7: A 32-byte block may start at any longword-aligned address. Cycles begin at that address, run upward and wrap to the start of the aligned 32-byte window until all 32 bytes have moved.
- R8: `ext_hold` is high from the first cycle of a transfer until its last cycle completes. Between cycles `ext_cyc` drops for exactly one clock while `ext_hold` stays high.
- R9: Each cycle holds `ext_cyc` high with a stable address until `ext_done` is seen high. No cycle starts before the previous one has completed.
- R10: `resp_valid` pulses for one clock, one clock after the edge on which the last cycle completes. On a read, `resp_rdata` holds the assembled bytes, and bits not covered by the request read as zero.
- R11: `req_ready` is low from the clock after a valid request is accepted until `resp_valid` is raised.
- R12: A request is rejected when a byte, half-word, longword, 8-byte or 16-byte request is not aligned to its size, a 32-byte request is not longword-aligned, the size code is above 5, the port code is 3, or a 32-bit port is used with the narrow-only flag. A rejected request produces `resp_valid` with `resp_err` on the next clock, issues no external cycle and leaves `req_ready` high.
- R13: During a cycle, `ext_be` marks exactly the lanes being transferred: one lane per byte moved, and S lanes in total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| endian_sel | input | 1 | Byte-order select, sampled during reset (0 big, 1 little) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the request |
| req_size | input | 3 | Request size code (R3) |
| req_port_w | input | 2 | External port width code (R3) |
| req_narrow_only | input | 1 | Port type restricted to 8 or 16 bits |
| req_wdata | input | 256 | Write data, longword j in bits 32j+31..32j |
| resp_valid | output | 1 | One-clock response pulse |
| resp_err | output | 1 | Response is a rejection |
| resp_rdata | output | 256 | Assembled read data |
| ext_cyc | output | 1 | External cycle strobe |
| ext_hold | output | 1 | External bus owned by the current transfer |
| ext_we | output | 1 | Current cycle is a write |
| ext_addr | output | ADDR_W | Address of the current cycle |
| ext_be | output | 4 | Active lanes of the current cycle |
| ext_wdata | output | 32 | Write data lanes |
| ext_rdata | input | 32 | Read data lanes |
| ext_done | input | 1 | Current cycle completes on this edge |

## Verification
The embedded properties watch the cycle-level handshake on every clock. They check that a cycle waits for its done input with a steady address, that the bus stays held across the one-clock gap between cycles, that the lane enables match the bytes moved, that ready is withdrawn after an accepted request, that a rejection leaves the external port quiet, and that the captured byte order never changes outside reset. The properties cannot show the content of a transfer: which addresses appear, in what order, and with which bytes on which lanes. The bench scenarios cover that. They sweep both byte orders, every port width, every size and every 32-byte starting longword. A byte-array memory model on the external side lets the bench compare memory after writes, and the assembled data after reads, against values computed from the layout rules.

// File: rtl/bws_pkg.sv
// Shared types for the bus width splitter.
// Assumes a 32-byte maximum block and an external port of at most 4 byte lanes.
package bws_pkg;
    localparam int unsigned BLK_LG    = 5;
    localparam int unsigned BLK_BYTES = 1 << BLK_LG;
    localparam int unsigned DATA_W    = 8 * BLK_BYTES;
    localparam int unsigned LANES     = 4;

    typedef enum logic [2:0] {
        SZ_BYTE  = 3'd0,
        SZ_HALF  = 3'd1,
        SZ_LONG  = 3'd2,
        SZ_BLK8  = 3'd3,
        SZ_BLK16 = 3'd4,
        SZ_BLK32 = 3'd5
    } xfer_size_e;

    typedef enum logic [1:0] {
        PORT_8  = 2'd0,
        PORT_16 = 2'd1,
        PORT_32 = 2'd2
    } port_w_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_GAP  = 2'd2
    } seq_state_e;

    // Per-transfer plan, log2 encoded.
    typedef struct packed {
        logic [BLK_LG-1:0] start_off; // first byte offset inside the aligned span
        logic [2:0]        t_lg;      // log2 of the transfer span in bytes
        logic [1:0]        elem_lg;   // log2 of the element size (<= 4 bytes)
        logic [1:0]        step_lg;   // log2 of bytes moved per external cycle
        logic [1:0]        pw_lg;     // log2 of the port width in bytes
        logic              write;
    } xfer_plan_t;
endpackage

// File: rtl/bws_decode.sv
// Request decoder: turns address, size and port code into a transfer plan and
// flags illegal requests. Purely combinational.
// Assumes that only requests with bad low pass to the sequencer.
module bws_decode
    import bws_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        size,
    input  logic [1:0]        port_w,
    input  logic              narrow_only,
    input  logic              write,
    output logic              bad,
    output logic [ADDR_W-1:0] base,
    output xfer_plan_t        plan
);
    logic [2:0]        t_lg;
    logic [1:0]        elem_lg;
    logic [1:0]        pw_lg;
    logic [BLK_LG:0]   span;
    logic [BLK_LG:0]   span_m1;
    logic [BLK_LG-1:0] off_mask;
    logic              misaligned;
    logic              size_bad;
    logic              port_bad;

    // Clamp codes and derive the span, the element size and the cycle step.
    always_comb begin
        size_bad = (size > 3'd5);
        port_bad = (port_w == 2'd3) || (narrow_only && port_w == PORT_32);
        t_lg     = size_bad ? 3'd0 : size;
        elem_lg  = (t_lg > 3'd2) ? 2'd2 : t_lg[1:0];
        pw_lg    = port_bad ? 2'd0 : port_w;
        span     = (BLK_LG+1)'(1) << t_lg;
        span_m1  = span - (BLK_LG+1)'(1);
        off_mask = span_m1[BLK_LG-1:0];
    end

    // Alignment rule: natural for sizes up to 16 bytes, longword for 32-byte blocks.
    always_comb begin
        if (t_lg == 3'(BLK_LG)) misaligned = (addr[1:0] != 2'b00);
        else                    misaligned = ((addr[BLK_LG-1:0] & off_mask) != '0);
    end

    // Assemble the plan and the aligned base address.
    always_comb begin
        bad            = size_bad || port_bad || misaligned;
        base           = addr & ~{{(ADDR_W-BLK_LG){1'b0}}, off_mask};
        plan.start_off = addr[BLK_LG-1:0] & off_mask;
        plan.t_lg      = t_lg;
        plan.elem_lg   = elem_lg;
        plan.pw_lg     = pw_lg;
        plan.step_lg   = (elem_lg < pw_lg) ? elem_lg : pw_lg;
        plan.write     = write;
    end
endmodule

// File: rtl/bws_seq.sv
// Cycle sequencer: runs the external cycles of one transfer. Each cycle
// holds the strobe until done. One strobe-low clock separates cycles while
// the bus stays held. Offsets wrap inside the aligned span.
// Assumes start is only raised while idle.
module bws_seq
    import bws_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  xfer_plan_t        plan_in,
    input  logic [ADDR_W-1:0] base_in,
    input  logic              ext_done,
    output logic              idle,
    output logic              ext_cyc,
    output logic              ext_hold,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [BLK_LG-1:0] cur_off,
    output logic              beat_fire,
    output logic              finish,
    output xfer_plan_t        plan_q
);
    localparam int unsigned CNT_W = BLK_LG + 1;

    seq_state_e        state_q;
    logic [CNT_W-1:0]  left_q;
    logic [BLK_LG-1:0] off_q;
    logic [ADDR_W-1:0] base_q;
    logic [BLK_LG:0]   span_m1;
    logic [BLK_LG-1:0] step;
    logic [CNT_W-1:0]  beats_in;

    // Span mask and step size of the running transfer; beat count of a new one.
    always_comb begin
        span_m1  = ((BLK_LG+1)'(1) << plan_q.t_lg) - (BLK_LG+1)'(1);
        step     = BLK_LG'(1) << plan_q.step_lg;
        beats_in = CNT_W'(1) << (plan_in.t_lg - {1'b0, plan_in.step_lg});
    end

    // Main state register: idle, cycle running, gap between cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            left_q  <= '0;
            off_q   <= '0;
            base_q  <= '0;
            plan_q  <= '0;
            finish  <= 1'b0;
        end else begin
            finish <= 1'b0;
            case (state_q)
                ST_IDLE: if (start) begin
                    state_q <= ST_RUN;
                    plan_q  <= plan_in;
                    base_q  <= base_in;
                    off_q   <= plan_in.start_off;
                    left_q  <= beats_in - CNT_W'(1);
                end
                ST_RUN: if (ext_done) begin
                    if (left_q == '0) begin
                        state_q <= ST_IDLE;
                        finish  <= 1'b1;
                    end else begin
                        state_q <= ST_GAP;
                        left_q  <= left_q - CNT_W'(1);
                        off_q   <= (off_q + step) & span_m1[BLK_LG-1:0];
                    end
                end
                ST_GAP:  state_q <= ST_RUN;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign idle      = (state_q == ST_IDLE);
    assign ext_cyc   = (state_q == ST_RUN);
    assign ext_hold  = (state_q != ST_IDLE);
    assign ext_addr  = base_q | {{(ADDR_W-BLK_LG){1'b0}}, off_q};
    assign cur_off   = off_q;
    assign beat_fire = ext_cyc && ext_done;

    // R8
    hold_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_hold && !ext_cyc) |=> ext_cyc);
    // R9
    wait_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_cyc && !ext_done) |=> (ext_cyc && $stable(ext_addr)));
    // R8
    hold_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_cyc |-> ext_hold);
endmodule

// File: rtl/bws_lane.sv
// Lane steering: maps each byte of the current cycle between the wide
// request data word and the external byte lanes, and builds read data.
// Assumes the current offset is a multiple of the cycle step.
module bws_lane
    import bws_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic              big,
    input  xfer_plan_t        plan,
    input  logic [1:0]        addr_lo,
    input  logic [BLK_LG-1:0] cur_off,
    input  logic              cyc,
    input  logic              capture,
    input  logic [8*LANES-1:0] ext_rdata,
    output logic [8*LANES-1:0] ext_wdata,
    output logic [LANES-1:0]   ext_be,
    output logic [DATA_W-1:0]  rdata
);
    localparam int unsigned BP_W = $clog2(DATA_W);

    logic [DATA_W-1:0] wacc_q;
    logic [1:0]        lane_a [LANES];
    logic [BP_W-1:0]   bp_a   [LANES];
    logic              en_a   [LANES];
    logic [1:0]        wmask;
    logic [1:0]        emask;
    logic [2:0]        nbytes;

    // Masks for port word and element, and bytes moved per cycle.
    always_comb begin
        wmask  = (plan.pw_lg == 2'd0) ? 2'd0 : (plan.pw_lg == 2'd1) ? 2'd1 : 2'd3;
        emask  = (plan.elem_lg == 2'd0) ? 2'd0 : (plan.elem_lg == 2'd1) ? 2'd1 : 2'd3;
        nbytes = 3'd1 << plan.step_lg;
    end

    // Per byte of the cycle: external lane and bit position in the wide word.
    for (genvar gi = 0; gi < LANES; gi++) begin : g_byte
        logic [BLK_LG-1:0] boff;
        logic [1:0]        alo;
        logic [1:0]        po;
        logic [1:0]        kk;
        logic [2:0]        jj;
        always_comb begin
            boff       = cur_off + BLK_LG'(gi);
            alo        = addr_lo + 2'(gi);
            po         = alo & wmask;
            kk         = boff[1:0] & emask;
            jj         = 3'(boff >> plan.elem_lg);
            en_a[gi]   = (3'(gi) < nbytes);
            lane_a[gi] = big ? (wmask - po) : po;
            bp_a[gi]   = {jj, (big ? (emask - kk) : kk), 3'b000};
        end
    end

    // Drive write lanes and lane enables for the current cycle.
    always_comb begin
        ext_wdata = '0;
        ext_be    = '0;
        if (cyc) begin
            for (int i = 0; i < LANES; i++) begin
                if (en_a[i]) begin
                    ext_wdata[8*lane_a[i] +: 8] = wacc_q[bp_a[i] +: 8];
                    ext_be[lane_a[i]]           = 1'b1;
                end
            end
        end
    end

    // Hold write data and collect read bytes as each cycle completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wacc_q <= '0;
            rdata  <= '0;
        end else if (load) begin
            wacc_q <= wdata_in;
            rdata  <= '0;
        end else if (capture) begin
            for (int i = 0; i < LANES; i++) begin
                if (en_a[i]) rdata[bp_a[i] +: 8] <= ext_rdata[8*lane_a[i] +: 8];
            end
        end
    end

    // R13
    lane_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc |-> ($countones(ext_be) == int'(nbytes)));
    // R13
    lane_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc |-> (ext_be == '0));
endmodule

// File: rtl/bus_width_splitter.sv
// Top of the bus width splitter: captures the byte order during reset,
// accepts one request at a time, runs it through the sequencer and lane
// steering, and returns a single response or a rejection.
// Assumes the external side answers every cycle with ext_done eventually.
module bus_width_splitter
    import bws_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              endian_sel,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_size,
    input  logic [1:0]        req_port_w,
    input  logic              req_narrow_only,
    input  logic [255:0]      req_wdata,
    output logic              resp_valid,
    output logic              resp_err,
    output logic [255:0]      resp_rdata,
    output logic              ext_cyc,
    output logic              ext_hold,
    output logic              ext_we,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [3:0]        ext_be,
    output logic [31:0]       ext_wdata,
    input  logic [31:0]       ext_rdata,
    input  logic              ext_done
);
    logic              big_q;
    logic              err_q;
    logic              accept;
    logic              bad;
    logic              idle;
    logic              finish;
    logic              beat_fire;
    logic [ADDR_W-1:0] base;
    logic [BLK_LG-1:0] cur_off;
    xfer_plan_t        plan;
    xfer_plan_t        plan_q;

    // Byte order follows the select pin while reset is held, then freezes.
    always_ff @(posedge clk) begin
        if (!rst_n) big_q <= !endian_sel;
    end

    assign req_ready = idle;
    assign accept    = req_valid && req_ready;

    bws_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr        (req_addr),
        .size        (req_size),
        .port_w      (req_port_w),
        .narrow_only (req_narrow_only),
        .write       (req_write),
        .bad         (bad),
        .base        (base),
        .plan        (plan)
    );

    bws_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept && !bad),
        .plan_in   (plan),
        .base_in   (base),
        .ext_done  (ext_done),
        .idle      (idle),
        .ext_cyc   (ext_cyc),
        .ext_hold  (ext_hold),
        .ext_addr  (ext_addr),
        .cur_off   (cur_off),
        .beat_fire (beat_fire),
        .finish    (finish),
        .plan_q    (plan_q)
    );

    bws_lane u_lane (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .wdata_in  (req_wdata),
        .big       (big_q),
        .plan      (plan_q),
        .addr_lo   (ext_addr[1:0]),
        .cur_off   (cur_off),
        .cyc       (ext_cyc),
        .capture   (beat_fire && !plan_q.write),
        .ext_rdata (ext_rdata),
        .ext_wdata (ext_wdata),
        .ext_be    (ext_be),
        .rdata     (resp_rdata)
    );

    // Rejection pulse, one clock after a bad request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= accept && bad;
    end

    assign resp_valid = finish || err_q;
    assign resp_err   = err_q;
    assign ext_we     = ext_cyc && plan_q.write;

    // R12
    reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && bad) |=> (!ext_cyc && !ext_hold && resp_err && req_ready));
    // R11
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !bad) |=> !req_ready);
    // R10
    resp_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_err) |-> $past(ext_cyc && ext_done));
    // R1
    order_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(big_q));
endmodule

// File: tb/sim_bus_width_splitter.sv
// Bench: byte-array memory on the external side, sweeps of byte order,
// port width, size and start offset, with expected data computed from R2/R6.
module sim_bus_width_splitter;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         endian_sel = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic         req_write = 1'b0;
    logic [31:0]  req_addr = '0;
    logic [2:0]   req_size = '0;
    logic [1:0]   req_port_w = '0;
    logic         req_narrow_only = 1'b0;
    logic [255:0] req_wdata = '0;
    logic         resp_valid;
    logic         resp_err;
    logic [255:0] resp_rdata;
    logic         ext_cyc;
    logic         ext_hold;
    logic         ext_we;
    logic [31:0]  ext_addr;
    logic [3:0]   ext_be;
    logic [31:0]  ext_wdata;
    logic [31:0]  ext_rdata = '0;
    logic         ext_done = 1'b0;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    logic [7:0]  mem    [256];
    logic [7:0]  shadow [256];
    logic [31:0] addr_log [64];
    int          n_log = 0;
    int          wcnt = 0;
    int          wlen = 0;
    bit          big_exp = 1'b1;
    int          cur_pw = 0;

    always #2.5 clk = ~clk;

    bus_width_splitter u0 (.*);

    // Watchdog: an expired run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            fails++;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 190000", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // External memory model: answers each cycle after 0..2 wait clocks.
    always @(negedge clk) begin
        if (!rst_n) begin
            ext_done <= 1'b0;
            wcnt = 0;
        end else if (ext_done) begin
            ext_done <= 1'b0;
        end else if (ext_cyc) begin
            if (wcnt >= wlen) begin
                int wb;
                int pb;
                logic [31:0] rd;
                wb = 1 << cur_pw;
                pb = int'(ext_addr[7:0]) & ~(wb - 1);
                if (n_log < 64) addr_log[n_log] = ext_addr;
                n_log++;
                rd = 32'hEEEE_EEEE;
                for (int l = 0; l < 4; l++) begin
                    if (l < wb) begin
                        int o;
                        o = big_exp ? (wb - 1 - l) : l;
                        if (ext_we && ext_be[l]) mem[(pb + o) & 255] = ext_wdata[8*l +: 8];
                        rd[8*l +: 8] = mem[(pb + o) & 255];
                    end
                end
                ext_rdata <= rd;
                ext_done  <= 1'b1;
                wcnt = 0;
                wlen = (wlen + 1) % 3;
            end else begin
                wcnt++;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [255:0] act, input logic [255:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Bit position of block byte 'off' in the wide data word (R2, R6).
    function automatic int bpos(input int off, input int t_lg, input bit big);
        int e_lg;
        int e;
        e_lg = (t_lg > 2) ? 2 : t_lg;
        e = 1 << e_lg;
        return 32 * (off / e) + 8 * (big ? (e - 1 - (off % e)) : (off % e));
    endfunction

    task automatic do_reset(input bit pin);
        @(negedge clk);
        rst_n = 1'b0;
        endian_sel = pin;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        endian_sel = ~pin;   // must be ignored from here on (R1)
        big_exp = ~pin;
        @(negedge clk);
        check(req_ready && !resp_valid && !ext_cyc && !ext_hold, "R11", "reset state",
              {252'd0, req_ready, resp_valid, ext_cyc, ext_hold}, 256'h8);
    endtask

    // Issue one request; report response fields and handshake violations.
    task automatic issue(input bit wr, input logic [31:0] a, input logic [2:0] sz,
                         input logic [1:0] pw, input bit narrow, input logic [255:0] wd,
                         output bit err, output logic [255:0] rd, output int bad_hold);
        int t;
        @(negedge clk);
        n_log = 0;
        cur_pw = int'(pw);
        req_write = wr; req_addr = a; req_size = sz; req_port_w = pw;
        req_narrow_only = narrow; req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        bad_hold = 0;
        t = 0;
        while (!resp_valid && t < 3000) begin
            if (!ext_hold || req_ready) bad_hold++;
            @(negedge clk);
            t++;
        end
        check(resp_valid, "R10", "response arrives", {255'd0, resp_valid}, 256'd1);
        err = resp_err;
        rd = resp_rdata;
    endtask

    // Full write + read case for one size, port and address.
    task automatic run_case(input int sz, input int pw, input int a);
        int t, e_lg, step, base, start, nb;
        logic [255:0] wd, rd, exp;
        bit err;
        int bh;
        bit ok;
        t = 1 << sz;
        e_lg = (sz > 2) ? 2 : sz;
        step = 1 << ((e_lg < pw) ? e_lg : pw);
        base = a & ~(t - 1);
        start = a & (t - 1);
        nb = t / step;
        for (int i = 0; i < 8; i++) wd[32*i +: 32] = $urandom;
        for (int i = 0; i < 256; i++) begin mem[i] = 8'h00; shadow[i] = 8'h00; end
        for (int off = 0; off < t; off++) shadow[base + off] = wd[bpos(off, sz, big_exp) +: 8];

        issue(1'b1, 32'(a), 3'(sz), 2'(pw), 1'b0, wd, err, rd, bh);
        check(!err, "R3", "legal write accepted", {255'd0, err}, 256'd0);
        ok = 1'b1;
        for (int i = 0; i < 256; i++) if (mem[i] !== shadow[i]) ok = 1'b0;
        check(ok, (sz > 2) ? "R6" : "R2", "memory after write", {248'd0, mem[base]}, {248'd0, shadow[base]});
        check(n_log == nb, (sz == 2 && pw == 0) ? "R5" : "R4", "cycle count", 256'(n_log), 256'(nb));
        ok = 1'b1;
        for (int i = 0; i < nb && i < 64; i++)
            if (addr_log[i] !== 32'(base + ((start + i * step) % t))) ok = 1'b0;
        check(ok, (sz == 5) ? "R7" : "R4", "address sequence", 256'(addr_log[0]), 256'(a));
        check(bh == 0, "R8", "bus held and ready low during transfer", 256'(bh), 256'd0);

        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3 + pw);
        exp = '0;
        for (int off = 0; off < t; off++) exp[bpos(off, sz, big_exp) +: 8] = mem[base + off];
        issue(1'b0, 32'(a), 3'(sz), 2'(pw), 1'b0, '0, err, rd, bh);
        check(!err && rd === exp, "R10", "assembled read data", rd, exp);
        check(bh == 0, "R11", "ready low during read", 256'(bh), 256'd0);
    endtask

    task automatic reject_case(input logic [31:0] a, input logic [2:0] sz,
                               input logic [1:0] pw, input bit narrow, input string what);
        bit err;
        logic [255:0] rd;
        int bh;
        issue(1'b1, a, sz, pw, narrow, '1, err, rd, bh);
        check(err && n_log == 0, "R12", what, {255'd0, err}, 256'd1);
        check(req_ready, "R12", "ready stays high on reject", {255'd0, req_ready}, 256'd1);
    endtask

    initial begin
        bit err;
        logic [255:0] rd;
        int bh;
        for (int pin = 0; pin < 2; pin++) begin
            do_reset(pin[0]);
            for (int sz = 0; sz < 6; sz++) begin
                for (int pw = 0; pw < 3; pw++) begin
                    if (sz < 5) begin
                        for (int m = 0; m < 2; m++) run_case(sz, pw, 'h40 + (1 << sz) * (m + 1));
                    end else begin
                        for (int s = 0; s < 8; s++) run_case(sz, pw, 'h60 + 4 * s);
                    end
                end
            end
            // R1: the pin was flipped after reset; a longword read shows the captured order.
            for (int i = 0; i < 256; i++) mem[i] = 8'(i);
            issue(1'b0, 32'h80, 3'd2, 2'd2, 1'b0, '0, err, rd, bh);
            check(rd[31:0] === (big_exp ? 32'h80818283 : 32'h83828180), "R1",
                  "captured byte order held", rd, 256'(big_exp ? 32'h80818283 : 32'h83828180));
            // R13: one byte on a 32-bit port moves on exactly its lane.
            for (int i = 0; i < 256; i++) mem[i] = 8'h00;
            issue(1'b1, 32'h91, 3'd0, 2'd2, 1'b0, 256'hA5, err, rd, bh);
            check(mem[8'h91] == 8'hA5 && mem[8'h90] == 8'h00 && mem[8'h92] == 8'h00 && mem[8'h93] == 8'h00,
                  "R13", "single lane write", {248'd0, mem[8'h91]}, 256'hA5);
        end
        reject_case(32'h41, 3'd1, 2'd2, 1'b0, "odd half-word");
        reject_case(32'h42, 3'd2, 2'd0, 1'b0, "misaligned longword");
        reject_case(32'h44, 3'd3, 2'd1, 1'b0, "misaligned 8-byte block");
        reject_case(32'h48, 3'd4, 2'd2, 1'b0, "misaligned 16-byte block");
        reject_case(32'h62, 3'd5, 2'd2, 1'b0, "32-byte block not longword aligned");
        reject_case(32'h40, 3'd6, 2'd2, 1'b0, "size code 6");
        reject_case(32'h40, 3'd2, 2'd3, 1'b0, "port code 3");
        reject_case(32'h40, 3'd2, 2'd2, 1'b1, "32-bit port on narrow-only type");
        // R3: narrow-only type still accepts a 16-bit port.
        issue(1'b0, 32'h40, 3'd2, 2'd1, 1'b1, '0, err, rd, bh);
        check(!err && n_log == 2, "R3", "narrow-only 16-bit port", 256'(n_log), 256'd2);
        repeat (4) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule